// File: doc/BRIEF.md
# Half-Step Head Positioner

This block moves a disk head stepper from the half-track it sits on to a requested half-track. A start strobe and a target position arrive together. The block subtracts the stored position from the target and takes the direction from the sign of the result. It then applies one half-step per stage by adding +1 or -1, modulo 4, to a 2-bit coil phase. After every half-step it holds for a fixed settling time. That time is a count of delay units, and each unit lasts a configurable number of clock cycles.

The phase bits share a control word with other bits, such as motor power and an activity lamp. Those other bits come in on a separate input and go out unchanged above the phase field. The stored position changes only when the whole move has finished. A request whose target equals the stored position finishes at once. A strobe that arrives during a move is dropped.

Top module: `halfstep_positioner`

## Requirements
- R1: After reset, position_o is RESET_POS (default 36), phase_o is 0, and busy_o and done_o are both low.
- R2: A strobe accepted while idle whose target equals position_o raises done_o for one cycle on the next clock and leaves busy_o low and phase_o unchanged.
- R3: For any other target, the move makes exactly |target - position| half-steps. They go upward (phase +1) when the target is greater and downward (phase -1) otherwise. busy_o is high for exactly steps x (1 + SETTLE_UNITS x UNIT_CYCLES) cycles, starting on the clock that accepts the strobe.
- R4: Each half-step changes phase_o by exactly +1 or -1 modulo 4. Upward, 3 wraps to 0; downward, 0 wraps to 3.
- R5: ctrl_o equals {ctrl_i, phase_o}. The phase sits in bits [1:0], and the upper CTRL_W-2 bits copy ctrl_i unchanged at every cycle.
- R6: After each phase change, phase_o and busy_o hold for exactly SETTLE_UNITS x UNIT_CYCLES cycles before the next half-step or the end of the move. SETTLE_UNITS defaults to 1024 (0x400).
- R7: position_o keeps its old value during a move. It takes the target on the same clock that raises done_o and drops busy_o.
- R8: A strobe that arrives while busy_o is high has no effect on the steps, the timing or the final position.
- R9: done_o is a single-cycle pulse and is never high together with busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Move request strobe |
| target_i | input | POS_W | Requested half-track, sampled with start_i |
| ctrl_i | input | CTRL_W-2 | Control bits that share the word with the phase |
| ctrl_o | output | CTRL_W | Control word: ctrl_i above the 2-bit phase |
| phase_o | output | 2 | Stepper coil phase |
| position_o | output | POS_W | Current half-track |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle move-complete pulse |

## Verification
The assertions assume a reset that lasts at least two cycles. They also assume the phase resets to 0, because the checker's copy of the previous phase starts there. The gap check on phase changes assumes a new move never begins in the same cycle that done_o is high. The bench keeps to this by always leaving an idle cycle after each completion before it raises the next strobe. Strobes during a move carry targets that differ from the active one, so a dropped request would show up as a wrong final position or a wrong step count.

// File: rtl/hsp_pkg.sv
// Shared types for the half-step positioner.
// Assumes nothing beyond a 2-bit state encoding.
package hsp_pkg;
    typedef enum logic [1:0] {
        HSP_IDLE   = 2'd0,
        HSP_STEP   = 2'd1,
        HSP_SETTLE = 2'd2
    } hsp_state_t;
endpackage

// File: rtl/hsp_plan.sv
// Move planner: forms the signed difference between the requested and the
// current half-track and gives the direction and the number of half-steps.
// Assumes both positions are unsigned POS_W-bit values.
module hsp_plan #(
    parameter int POS_W = 8
) (
    input  logic [POS_W-1:0] target_i,
    input  logic [POS_W-1:0] current_i,
    output logic             same_o,
    output logic             up_o,
    output logic [POS_W-1:0] span_o
);
    logic [POS_W:0] diff;

    // Signed difference, direction and magnitude.
    always_comb begin
        diff   = {1'b0, target_i} - {1'b0, current_i};
        same_o = (diff == '0);
        up_o   = !diff[POS_W] && !same_o;
        span_o = diff[POS_W] ? (current_i - target_i) : diff[POS_W-1:0];
    end
endmodule

// File: rtl/hsp_phase.sv
// Phase register: one modulo-4 add of +1 or -1 per step request.
// Assumes step_i is a single-cycle request.
module hsp_phase (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic       up_i,
    output logic [1:0] phase_o
);
    // Advance or retreat the two phase bits, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_o <= 2'd0;
        else if (step_i)
            phase_o <= phase_o + (up_i ? 2'd1 : 2'd3);
    end
endmodule

// File: rtl/hsp_settle.sv
// Settling timer: a prescaler of UNIT_CYCLES clocks feeding a counter of
// SETTLE_UNITS units. expire_o is high in the last cycle of the window.
// Assumes clear_i is held whenever run_i is low, so every window starts at 0.
module hsp_settle #(
    parameter int UNIT_CYCLES  = 1,
    parameter int SETTLE_UNITS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int PW = (UNIT_CYCLES  > 1) ? $clog2(UNIT_CYCLES)  : 1;
    localparam int UW = (SETTLE_UNITS > 1) ? $clog2(SETTLE_UNITS) : 1;
    localparam logic [PW-1:0] PRE_LAST  = PW'(UNIT_CYCLES - 1);
    localparam logic [UW-1:0] UNIT_LAST = UW'(SETTLE_UNITS - 1);

    logic [PW-1:0] pre_q;
    logic [UW-1:0] unit_q;

    // Flag the final cycle of the window.
    always_comb expire_o = run_i && (pre_q == PRE_LAST) && (unit_q == UNIT_LAST);

    // Count clocks within a unit, then units within the window.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            pre_q  <= '0;
            unit_q <= '0;
        end else if (run_i) begin
            if (pre_q == PRE_LAST) begin
                pre_q  <= '0;
                unit_q <= (unit_q == UNIT_LAST) ? '0 : unit_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/halfstep_positioner.sv
// Half-step positioner top. It accepts a target half-track while idle,
// steps the 2-bit phase once per stage with a settling window after each
// step, and updates the stored position when the last window ends.
// Assumes start_i and target_i are synchronous to clk.
module halfstep_positioner
    import hsp_pkg::*;
#(
    parameter int POS_W        = 8,
    parameter int CTRL_W       = 8,
    parameter int RESET_POS    = 36,
    parameter int SETTLE_UNITS = 1024,
    parameter int UNIT_CYCLES  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [POS_W-1:0]  target_i,
    input  logic [CTRL_W-3:0] ctrl_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [1:0]        phase_o,
    output logic [POS_W-1:0]  position_o,
    output logic              busy_o,
    output logic              done_o
);
    hsp_state_t       state_q;
    logic [POS_W-1:0] dest_q;
    logic [POS_W-1:0] left_q;
    logic             up_q;
    logic             plan_same;
    logic             plan_up;
    logic [POS_W-1:0] plan_span;
    logic             expire;

    hsp_plan #(.POS_W(POS_W)) plan_i (
        .target_i  (target_i),
        .current_i (position_o),
        .same_o    (plan_same),
        .up_o      (plan_up),
        .span_o    (plan_span)
    );

    hsp_phase phase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (state_q == HSP_STEP),
        .up_i    (up_q),
        .phase_o (phase_o)
    );

    hsp_settle #(
        .UNIT_CYCLES  (UNIT_CYCLES),
        .SETTLE_UNITS (SETTLE_UNITS)
    ) settle_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (state_q != HSP_SETTLE),
        .run_i    (state_q == HSP_SETTLE),
        .expire_o (expire)
    );

    // Outputs: busy flag and the merged control word.
    always_comb begin
        busy_o = (state_q != HSP_IDLE);
        ctrl_o = {ctrl_i, phase_o};
    end

    // Sequencer: accept, step, settle, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= HSP_IDLE;
            position_o <= POS_W'(RESET_POS);
            dest_q     <= '0;
            left_q     <= '0;
            up_q       <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                HSP_IDLE: begin
                    if (start_i) begin
                        if (plan_same) begin
                            done_o <= 1'b1;
                        end else begin
                            dest_q  <= target_i;
                            up_q    <= plan_up;
                            left_q  <= plan_span;
                            state_q <= HSP_STEP;
                        end
                    end
                end
                HSP_STEP: state_q <= HSP_SETTLE;
                HSP_SETTLE: begin
                    if (expire) begin
                        if (left_q == POS_W'(1)) begin
                            position_o <= dest_q;
                            done_o     <= 1'b1;
                            state_q    <= HSP_IDLE;
                        end else begin
                            left_q  <= left_q - 1'b1;
                            state_q <= HSP_STEP;
                        end
                    end
                end
                default: state_q <= HSP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hsp_checker.sv
// Property checker for the half-step positioner, bound to every instance.
// Assumes reset is held for at least two cycles and the phase resets to 0.
module hsp_checker #(
    parameter int POS_W         = 8,
    parameter int SETTLE_CYCLES = 1024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [POS_W-1:0] target_i,
    input logic [1:0]       phase_o,
    input logic [POS_W-1:0] position_o,
    input logic             busy_o,
    input logic             done_o
);
    localparam int GW = $clog2(SETTLE_CYCLES + 3) + 1;
    localparam logic [GW-1:0] GMAX = '1;

    logic [1:0]    phase_q;
    logic [GW-1:0] gap_q;
    logic          seen_q;
    logic          chg;

    always_comb chg = (phase_o != phase_q);

    // Track the previous phase, the cycles since the last change, and
    // whether this move has already stepped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 2'd0;
            gap_q   <= '0;
            seen_q  <= 1'b0;
        end else begin
            phase_q <= phase_o;
            if (chg)
                gap_q <= GW'(1);
            else if (gap_q != GMAX)
                gap_q <= gap_q + 1'b1;
            if (!busy_o)
                seen_q <= 1'b0;
            else if (chg)
                seen_q <= 1'b1;
        end
    end

    a_r2_equal_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (target_i == position_o)) |=> (done_o && !busy_o && $stable(phase_o)));

    a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> ((phase_o - phase_q == 2'd1) || (phase_o - phase_q == 2'd3)));

    a_r3_step_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> busy_o);

    a_r6_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && seen_q) |-> (gap_q == GW'(SETTLE_CYCLES + 1)));

    a_r6_final_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && seen_q) |-> (gap_q == GW'(SETTLE_CYCLES)));

    a_r7_position_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(position_o) |-> done_o);

    a_r9_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind halfstep_positioner hsp_checker #(
    .POS_W         (POS_W),
    .SETTLE_CYCLES (SETTLE_UNITS * UNIT_CYCLES)
) hsp_checker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .target_i   (target_i),
    .phase_o    (phase_o),
    .position_o (position_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/halfstep_positioner_tb_top.sv
// Sweep bench: every target from 0 to 63, each reached from the previous
// position and followed by a return to 36, with occasional stray strobes.
module halfstep_positioner_tb_top;
    localparam int POS_W = 6;
    localparam int CTRL_W = 8;
    localparam int SU = 4;
    localparam int UC = 3;
    localparam int SC = SU * UC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [POS_W-1:0]  target = '0;
    logic [CTRL_W-3:0] ctrl_in = '0;
    logic [CTRL_W-1:0] ctrl_out;
    logic [1:0]        phase;
    logic [POS_W-1:0]  position;
    logic              busy;
    logic              done;

    int total = 0;
    int bad = 0;
    int exp_pos = 36;
    int exp_phase = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    halfstep_positioner #(
        .POS_W(POS_W), .CTRL_W(CTRL_W), .RESET_POS(36),
        .SETTLE_UNITS(SU), .UNIT_CYCLES(UC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .target_i(target),
        .ctrl_i(ctrl_in), .ctrl_o(ctrl_out), .phase_o(phase),
        .position_o(position), .busy_o(busy), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_word();
        check(ctrl_out == {ctrl_in, 2'(exp_phase)}, "R5 control word", ctrl_out,
              int'({ctrl_in, 2'(exp_phase)}));
    endtask

    task automatic move(input int t, input bit inj);
        int n;
        bit up;
        n = t - exp_pos;
        up = (n > 0);
        if (n < 0) n = -n;
        @(negedge clk);
        start = 1'b1;
        target = POS_W'(t);
        ctrl_in = 6'(t * 37 + 11);
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            check(done == 1'b1, "R2 done", done, 1);
            check(busy == 1'b0, "R2 busy", busy, 0);
            check(phase == 2'(exp_phase), "R2 phase", phase, exp_phase);
            check(position == POS_W'(exp_pos), "R7 position", position, exp_pos);
        end else begin
            check(busy == 1'b1, "R3 busy", busy, 1);
            check(done == 1'b0, "R9 done", done, 0);
            for (int k = 1; k <= n; k++) begin
                @(negedge clk);
                exp_phase = (exp_phase + (up ? 1 : 3)) % 4;
                check(phase == 2'(exp_phase), up ? "R3 R4 up phase" : "R3 R4 down phase",
                      phase, exp_phase);
                check(position == POS_W'(exp_pos), "R7 position hold", position, exp_pos);
                check_word();
                for (int j = 1; j <= SC; j++) begin
                    if (inj && k == 1 && j == 1) begin
                        start = 1'b1;            // R8 stray strobe
                        target = POS_W'(t ^ 21);
                    end else begin
                        start = 1'b0;
                    end
                    @(negedge clk);
                    if (j < SC)
                        check(phase == 2'(exp_phase) && busy, "R6 settle hold", phase, exp_phase);
                end
                start = 1'b0;
                if (k < n) begin
                    check(busy == 1'b1, "R6 busy at window end", busy, 1);
                    check(phase == 2'(exp_phase), "R6 phase at window end", phase, exp_phase);
                end else begin
                    check(done == 1'b1, "R3 done after last window", done, 1);
                    check(busy == 1'b0, "R9 busy low with done", busy, 0);
                    check(position == POS_W'(t), inj ? "R8 R7 final position" : "R7 final position",
                          position, t);
                end
            end
        end
        exp_pos = t;
        @(negedge clk);
        check(done == 1'b0, "R9 single pulse", done, 0);
        check(busy == 1'b0, "R3 idle", busy, 0);
        check_word();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(position == 6'd36, "R1 position", position, 36);
        check(phase == 2'd0, "R1 phase", phase, 0);
        check(!busy && !done, "R1 flags", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(position == 6'd36 && !busy && !done, "R1 after release", position, 36);
        move(36, 1'b0);
        for (int t = 0; t < 64; t++) begin
            move(t, (t % 7) == 0);
            move(t, 1'b0);
            move(36, (t % 5) == 0);
        end
        move(37, 1'b0);
        move(38, 1'b0);
        move(39, 1'b0);
        move(40, 1'b0);
        move(36, 1'b0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule